// File: doc/BRIEF.md
# Pseudo-Random Link Test Stream Generator and Checker

This block drives and verifies a pseudo-random test pattern on the 16-bit parallel user side of a serial transceiver. It is meant for long soak tests of a link, where the bit error rate is measured. The transmit half runs a 16-bit linear feedback shift register. It sends a repeating four-slot frame: three register words as data, then one alignment word marked as a control character.

The receive half starts out hunting. It arms itself when it sees the alignment word. It then seeds its own copy of the shift register from the next data word it receives. From that point it predicts every later data word. Each data word that differs from the prediction adds one to a word error counter. The number of differing bits is added to a bit error counter.

Alignment slots are skipped while the checker is locked. A run of consecutive bad words drops lock, and the checker waits for a fresh alignment word. Both counters saturate instead of wrapping, so a long run never loses errors. A synchronous clear input resets both counters.

Top module: `prbs_link_test`

## Requirements
- R1: While reset is held, the block shows the seed word 16'hACE1 on `tx_data` with `tx_is_ctrl` low, `locked` low and both error counters at zero.
- R2: Each shift-register advance moves bits 14..0 up into bits 15..1 and fills bit 0 with the XOR of old bits 0, 5, 10 and 15. An all-zero result is replaced by the seed 16'hACE1.
- R3: The transmit stream repeats a four-word frame. Slots 0 to 2 carry the current register value with `tx_is_ctrl` low. Slot 3 carries the alignment word 16'h50BC with `tx_is_ctrl` high. The register advances after each data slot and holds across the alignment slot.
- R4: From the unlocked state, a received word with `rx_is_ctrl` high and value 16'h50BC arms the checker. The next received word with `rx_is_ctrl` low seeds the prediction, and `locked` rises after that edge. No error is counted for that word.
- R5: While locked, each received data word that differs from the predicted word adds one to `word_err_cnt` one cycle later.
- R6: For each such mismatch, `bit_err_cnt` grows by the number of differing bit positions.
- R7: While locked, a received alignment word (control flag high, value 16'h50BC) is not compared, counts no error and does not advance the prediction.
- R8: While locked, a received word with the control flag high and any value other than 16'h50BC adds one word error and no bit errors. It advances the prediction and counts toward the bad-word run.
- R9: Eight consecutive erroneous words (data or control) drop `locked`. Lock returns only after a new alignment word followed by a data word.
- R10: Both counters stop at their all-ones value and never wrap.
- R11: `clr_cnt` high at a clock edge zeroes both counters, and takes priority over an increment on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_cnt | input | 1 | Synchronous clear of both error counters |
| tx_data | output | 16 | Transmit word to the transceiver |
| tx_is_ctrl | output | 1 | Marks the transmit word as a control character |
| rx_data | input | 16 | Received word from the transceiver |
| rx_is_ctrl | input | 1 | Received word was a control character |
| locked | output | 1 | Checker is synchronised to the incoming stream |
| word_err_cnt | output | CNT_W (32) | Saturating count of erroneous words |
| bit_err_cnt | output | CNT_W (32) | Saturating count of erroneous bits |

## Verification
The bench places single-bit and byte-wide faults on data slots and compares the exact counter deltas. A checker that counted words but miscounted bits, or that also compared the alignment slot, would then show the wrong totals.

It forces an alignment word into a data slot. A design that advanced its prediction there would miss the resulting slip, and one that counted the word itself would show a spurious error. It also forces a bad control word, which must count one word and zero bits.

A burst of corrupted words checks that lock drops after exactly eight errors and returns only through a new alignment. A long fault run on a narrowed counter exposes any wrap at the all-ones value. A clear pulse in the same cycle as an error exposes wrong clear priority.

// File: rtl/prbs_link_pkg.sv
package prbs_link_pkg;

    localparam int WORD_W = 16;
    localparam int POP_W  = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t data;
        logic  is_ctrl;
    } lane_t;

    typedef enum logic [1:0] {
        CHK_HUNT   = 2'd0,
        CHK_ARMED  = 2'd1,
        CHK_LOCKED = 2'd2
    } chk_state_e;

    // One shift-register advance with zero-state recovery.
    function automatic word_t lfsr_step(word_t cur, word_t seed);
        word_t nxt;
        nxt = {cur[14:0], cur[0] ^ cur[5] ^ cur[10] ^ cur[15]};
        return (nxt == '0) ? seed : nxt;
    endfunction

    function automatic logic [POP_W-1:0] pop_word(word_t w);
        logic [POP_W-1:0] n;
        n = '0;
        for (int i = 0; i < WORD_W; i++) begin
            n = n + POP_W'(w[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_link_pkg::*;
#(
    parameter word_t SEED      = 16'hACE1,
    parameter word_t ALIGN     = 16'h50BC,
    parameter int    FRAME_LEN = 4
) (
    input  logic  clk,
    input  logic  rst,
    output lane_t tx
);
    localparam int SLOT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

    logic [SLOT_W-1:0] slot_q;
    word_t             state_q;
    logic              align_slot;

    assign align_slot = (slot_q == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            state_q <= SEED;
        end else begin
            slot_q <= align_slot ? '0 : slot_q + 1'b1;
            if (!align_slot) begin
                state_q <= lfsr_step(state_q, SEED);
            end
        end
    end

    always_comb begin
        tx.is_ctrl = align_slot;
        tx.data    = align_slot ? ALIGN : state_q;
    end

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_link_pkg::*;
#(
    parameter word_t SEED     = 16'hACE1,
    parameter word_t ALIGN    = 16'h50BC,
    parameter int    LOSS_RUN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_t            rx,
    output logic             locked,
    output logic             err_word,
    output logic [POP_W-1:0] err_bits
);
    localparam int RUN_W = (LOSS_RUN > 1) ? $clog2(LOSS_RUN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOSS_RUN - 1);

    chk_state_e       state_q, state_n;
    word_t            pred_q, pred_n;
    logic [RUN_W-1:0] run_q, run_n;
    logic             is_align;
    word_t            diff;

    assign is_align = rx.is_ctrl && (rx.data == ALIGN);
    assign diff     = rx.data ^ pred_q;
    assign locked   = (state_q == CHK_LOCKED);

    always_comb begin
        state_n  = state_q;
        pred_n   = pred_q;
        run_n    = run_q;
        err_word = 1'b0;
        err_bits = '0;
        case (state_q)
            CHK_HUNT: begin
                if (is_align) state_n = CHK_ARMED;
            end
            CHK_ARMED: begin
                if (!rx.is_ctrl) begin
                    pred_n  = lfsr_step(rx.data, SEED);
                    run_n   = '0;
                    state_n = CHK_LOCKED;
                end
            end
            CHK_LOCKED: begin
                if (!is_align) begin
                    pred_n   = lfsr_step(pred_q, SEED);
                    err_word = rx.is_ctrl || (diff != '0);
                    err_bits = rx.is_ctrl ? '0 : pop_word(diff);
                    if (err_word) begin
                        if (run_q == RUN_LAST) begin
                            run_n   = '0;
                            state_n = CHK_HUNT;
                        end else begin
                            run_n = run_q + 1'b1;
                        end
                    end else begin
                        run_n = '0;
                    end
                end
            end
            default: state_n = CHK_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CHK_HUNT;
            pred_q  <= SEED;
            run_q   <= '0;
        end else begin
            state_q <= state_n;
            pred_q  <= pred_n;
            run_q   <= run_n;
        end
    end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     count
);
    logic [W:0] sum;

    assign sum = {1'b0, count} + (W + 1)'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (sum[W]) begin
            count <= '1;
        end else begin
            count <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/prbs_link_test.sv
module prbs_link_test
    import prbs_link_pkg::*;
#(
    parameter int    CNT_W     = 32,
    parameter word_t SEED      = 16'hACE1,
    parameter word_t ALIGN     = 16'h50BC,
    parameter int    FRAME_LEN = 4,
    parameter int    LOSS_RUN  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_cnt,
    output logic [15:0]      tx_data,
    output logic             tx_is_ctrl,
    input  logic [15:0]      rx_data,
    input  logic             rx_is_ctrl,
    output logic             locked,
    output logic [CNT_W-1:0] word_err_cnt,
    output logic [CNT_W-1:0] bit_err_cnt
);
    lane_t            tx_lane, rx_lane;
    logic             err_word;
    logic [POP_W-1:0] err_bits;
    logic [POP_W-1:0] inc_arr [2];
    logic [CNT_W-1:0] cnt_arr [2];

    prbs_gen #(.SEED(SEED), .ALIGN(ALIGN), .FRAME_LEN(FRAME_LEN)) u_gen (
        .clk (clk),
        .rst (rst),
        .tx  (tx_lane)
    );

    assign tx_data    = tx_lane.data;
    assign tx_is_ctrl = tx_lane.is_ctrl;
    assign rx_lane    = '{data: rx_data, is_ctrl: rx_is_ctrl};

    prbs_chk #(.SEED(SEED), .ALIGN(ALIGN), .LOSS_RUN(LOSS_RUN)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .rx       (rx_lane),
        .locked   (locked),
        .err_word (err_word),
        .err_bits (err_bits)
    );

    assign inc_arr[0] = POP_W'(err_word);
    assign inc_arr[1] = err_bits;

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        sat_counter #(.W(CNT_W), .INC_W(POP_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr_cnt),
            .inc   (inc_arr[g]),
            .count (cnt_arr[g])
        );
    end

    assign word_err_cnt = cnt_arr[0];
    assign bit_err_cnt  = cnt_arr[1];

endmodule

// File: rtl/prbs_link_sva.sv
module prbs_link_sva
    import prbs_link_pkg::*;
#(
    parameter int    CNT_W = 32,
    parameter word_t SEED  = 16'hACE1,
    parameter word_t ALIGN = 16'h50BC
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_cnt,
    input logic [15:0]      tx_data,
    input logic             tx_is_ctrl,
    input logic             rx_is_ctrl,
    input logic             locked,
    input logic [CNT_W-1:0] word_err_cnt,
    input logic [CNT_W-1:0] bit_err_cnt
);
    AST_ALIGN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_is_ctrl |=> !tx_is_ctrl); // R3
    AST_ALIGN_VALUE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_is_ctrl) |-> tx_data == ALIGN); // R3
    AST_HOLD_ACROSS_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (!tx_is_ctrl && $past(tx_is_ctrl)) |-> tx_data == lfsr_step($past(tx_data, 2), SEED)); // R2
    AST_LOCK_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> !$past(rx_is_ctrl)); // R4
    AST_LOCK_NO_ERROR: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (word_err_cnt == $past(word_err_cnt) || $past(clr_cnt))); // R4
    AST_WORD_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$past(clr_cnt) |-> word_err_cnt >= $past(word_err_cnt)); // R10
    AST_BIT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$past(clr_cnt) |-> bit_err_cnt >= $past(bit_err_cnt)); // R10
    AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(clr_cnt) |-> (bit_err_cnt - $past(bit_err_cnt)) <= CNT_W'(16)); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(clr_cnt) |-> (word_err_cnt == '0 && bit_err_cnt == '0)); // R11
endmodule

bind prbs_link_test prbs_link_sva #(.CNT_W(CNT_W), .SEED(SEED), .ALIGN(ALIGN)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .clr_cnt      (clr_cnt),
    .tx_data      (tx_data),
    .tx_is_ctrl   (tx_is_ctrl),
    .rx_is_ctrl   (rx_is_ctrl),
    .locked       (locked),
    .word_err_cnt (word_err_cnt),
    .bit_err_cnt  (bit_err_cnt)
);

// File: tb/prbs_link_test_bench.sv
`timescale 1ns/100ps
module prbs_link_test_bench;
    localparam int          CW      = 10;
    localparam logic [15:0] K_SEED  = 16'hACE1;
    localparam logic [15:0] K_ALIGN = 16'h50BC;
    localparam longint      CMAX    = (64'd1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_cnt = 1'b0;
    logic [15:0]   tx_data;
    logic          tx_is_ctrl;
    logic [15:0]   rx_data;
    logic          rx_is_ctrl;
    logic          locked;
    logic [CW-1:0] word_err_cnt;
    logic [CW-1:0] bit_err_cnt;

    logic [15:0] err_mask = '0;
    logic        ovr_en   = 1'b0;
    logic [15:0] ovr_data = '0;
    logic        ovr_ctrl = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    assign rx_data    = ovr_en ? ovr_data : (tx_data ^ err_mask);
    assign rx_is_ctrl = ovr_en ? ovr_ctrl : tx_is_ctrl;

    prbs_link_test #(.CNT_W(CW)) u_prbs_link_test (
        .clk          (clk),
        .rst          (rst),
        .clr_cnt      (clr_cnt),
        .tx_data      (tx_data),
        .tx_is_ctrl   (tx_is_ctrl),
        .rx_data      (rx_data),
        .rx_is_ctrl   (rx_is_ctrl),
        .locked       (locked),
        .word_err_cnt (word_err_cnt),
        .bit_err_cnt  (bit_err_cnt)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model
    function automatic logic [15:0] m_adv(input logic [15:0] s);
        logic [15:0] n;
        n = (s << 1) | 16'(^(s & 16'h8421));
        if (n == 16'h0000) n = K_SEED;
        return n;
    endfunction

    logic [15:0] m_st;
    int          m_slot;
    int          m_mode;   // 0 hunting, 1 armed, 2 locked
    logic [15:0] m_pred;
    int          m_run;
    longint      m_wc, m_bc;
    logic [15:0] s_rx;
    logic        s_ctrl, s_clr;

    always @(posedge clk) begin
        if (rst) begin
            m_st = K_SEED; m_slot = 0; m_mode = 0; m_pred = K_SEED;
            m_run = 0; m_wc = 0; m_bc = 0;
        end else begin
            int  dw, db;
            bit  al;
            dw = 0; db = 0;
            al = s_ctrl && (s_rx == K_ALIGN);
            if (m_mode == 0) begin
                if (al) m_mode = 1;
            end else if (m_mode == 1) begin
                if (!s_ctrl) begin m_pred = m_adv(s_rx); m_run = 0; m_mode = 2; end
            end else if (!al) begin
                if (s_ctrl) dw = 1;
                else if (s_rx != m_pred) begin dw = 1; db = $countones(s_rx ^ m_pred); end
                m_pred = m_adv(m_pred);
                if (dw != 0) begin
                    m_run++;
                    if (m_run == 8) begin m_run = 0; m_mode = 0; end
                end else m_run = 0;
            end
            if (s_clr) begin m_wc = 0; m_bc = 0; end
            else begin
                m_wc = (m_wc + dw > CMAX) ? CMAX : m_wc + dw;
                m_bc = (m_bc + db > CMAX) ? CMAX : m_bc + db;
            end
            if (m_slot != 3) m_st = m_adv(m_st);
            m_slot = (m_slot + 1) % 4;
        end
        started = 1;
    end

    // Per-cycle comparison and input capture, away from the edge
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            logic [15:0] et;
            et = (m_slot == 3) ? K_ALIGN : m_st;
            check(tx_data == et && tx_is_ctrl == (m_slot == 3), "R2/R3 tx word",
                  {tx_is_ctrl, tx_data}, {(m_slot == 3), et});
            check(locked == (m_mode == 2), "R4/R9 lock", locked, (m_mode == 2));
            check(word_err_cnt == m_wc && bit_err_cnt == m_bc, "R5/R6/R8/R10 counts",
                  {word_err_cnt, bit_err_cnt}, {m_wc[CW-1:0], m_bc[CW-1:0]});
        end
        s_rx = rx_data; s_ctrl = rx_is_ctrl; s_clr = clr_cnt;
    end

    task automatic to_data_slot();
        @(negedge clk);
        while (m_slot == 3) @(negedge clk);
    endtask

    task automatic inject(input logic [15:0] msk, input string tag);
        longint w0, b0;
        to_data_slot();
        w0 = word_err_cnt; b0 = bit_err_cnt;
        err_mask = msk;
        @(negedge clk);
        err_mask = '0;
        #2;
        check(word_err_cnt == w0 + 1, {tag, " word delta"}, word_err_cnt, w0 + 1);
        check(bit_err_cnt == b0 + $countones(msk), {tag, " bit delta"}, bit_err_cnt, b0 + $countones(msk));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(tx_data == K_SEED && !tx_is_ctrl, "R1 reset tx", tx_data, K_SEED);
        check(!locked, "R1 reset lock", locked, 0);
        check(word_err_cnt == 0 && bit_err_cnt == 0, "R1 reset counts", word_err_cnt, 0);
        @(negedge clk); rst = 1'b0;

        repeat (40) @(negedge clk);
        #2;
        check(locked, "R4 lock acquired", locked, 1);
        check(word_err_cnt == 0 && bit_err_cnt == 0, "R7 clean stream no errors", word_err_cnt, 0);

        inject(16'h0001, "R5/R6 single bit");
        repeat (5) @(negedge clk);
        inject(16'h00FF, "R5/R6 byte");
        repeat (5) @(negedge clk);
        inject(16'hA5A5, "R6 pattern");

        begin : bad_ctrl
            longint w0, b0;
            repeat (5) @(negedge clk);
            to_data_slot();
            w0 = word_err_cnt; b0 = bit_err_cnt;
            ovr_en = 1; ovr_data = 16'h1234; ovr_ctrl = 1;
            @(negedge clk); ovr_en = 0;
            #2;
            check(word_err_cnt == w0 + 1 && bit_err_cnt == b0, "R8 bad control word",
                  {word_err_cnt, bit_err_cnt}, {w0[CW-1:0] + CW'(1), b0[CW-1:0]});
        end

        begin : align_in_slot
            longint w0;
            repeat (5) @(negedge clk);
            to_data_slot();
            w0 = word_err_cnt;
            ovr_en = 1; ovr_data = K_ALIGN; ovr_ctrl = 1;
            @(negedge clk); ovr_en = 0;
            #2;
            check(word_err_cnt == w0 && locked, "R7 align word skipped", word_err_cnt, w0);
        end

        repeat (80) @(negedge clk);
        #2;
        check(locked, "R4 relock after slip", locked, 1);

        @(negedge clk);
        err_mask = 16'hFFFF;
        repeat (12) @(negedge clk);
        err_mask = '0;
        #2;
        check(!locked, "R9 lock lost after run", locked, 0);
        repeat (40) @(negedge clk);
        #2;
        check(locked, "R9 relock via alignment", locked, 1);

        @(negedge clk); clr_cnt = 1;
        @(negedge clk); clr_cnt = 0;
        #2;
        check(word_err_cnt == 0 && bit_err_cnt == 0, "R11 clear", word_err_cnt, 0);

        to_data_slot();
        clr_cnt = 1; err_mask = 16'h0F0F;
        @(negedge clk); clr_cnt = 0; err_mask = '0;
        #2;
        check(word_err_cnt == 0 && bit_err_cnt == 0, "R11 clear beats increment", bit_err_cnt, 0);

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            err_mask = (m_slot == 3) ? 16'h0000 : 16'hFFFF;
        end
        @(negedge clk); err_mask = '0;
        #2;
        check(word_err_cnt == CW'(CMAX), "R10 word saturation", word_err_cnt, CMAX);
        check(bit_err_cnt == CW'(CMAX), "R10 bit saturation", bit_err_cnt, CMAX);

        @(negedge clk); clr_cnt = 1;
        @(negedge clk); clr_cnt = 0;
        #2;
        check(word_err_cnt == 0 && bit_err_cnt == 0, "R11 clear from saturation", word_err_cnt, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule